// File: doc/BRIEF.md
# Posted Write Buffer with Read Forwarding

This block stages write bursts between a burst write port and a memory array. Each burst carries one address, four data beats and a separate active-low byte-enable mask for every beat. The block keeps the two most recent bursts pending. It passes the oldest one to the array only when a third write arrives, so array updates trail the write stream by two write operations.

A combinational lookup port keeps reads coherent while writes are held back. The caller presents a read address together with the array's data for that address. The block returns the array data, overlaid byte by byte with any enabled bytes from pending bursts that match the address. A newer burst takes precedence over an older one. A drain input empties the buffer one burst per cycle, oldest first, so that the array contents become final.

Top module: `posted_write_buffer`

## Requirements
- R1: After reset no burst is pending, so a lookup returns `rd_array_data` unchanged. Each cycle with `wr_en` high at a rising edge stores one burst. The first two writes into an empty buffer raise no commit.
- R2: A write arriving while two bursts are pending raises `cm_valid` combinationally in that same cycle. The commit outputs carry the oldest burst's address, data and byte enables. At the edge the oldest burst leaves the buffer, and the incoming burst becomes the newest.
- R3: A lookup to the address written one cycle earlier, with every byte enable of that burst at 0, returns all four of that burst's beats exactly.
- R4: The data layout is as follows. Beat k occupies bits [k*32 +: 32] and byte j of that beat occupies bits [k*32 + j*8 +: 8]. Its enable is bit k*4+j of the mask, and 0 means write. A lookup byte comes from a matching pending burst only where that burst's enable is 0. Otherwise it comes from the array data.
- R5: When both pending bursts match the lookup address, a byte enabled in the newer burst is taken from the newer burst. A byte enabled only in the older burst is taken from the older burst.
- R6: A cycle with `wr_en` and `drain` both low raises no commit, and the set of pending bursts stays as it was.
- R7: With `drain` high and `wr_en` low, the oldest pending burst is committed and removed, one per cycle. Draining an empty buffer commits nothing. When `wr_en` and `drain` are both high, only the write acts.
- R8: A lookup reflects the bursts pending before the current edge. A lookup to the address being committed in that cycle is still served from the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Accept a write burst at this edge |
| wr_addr | input | ADDR_W | Burst address of the write |
| wr_data | input | 4*BYTES*BYTE_W | Four beats of write data, beat 0 in the low bits |
| wr_ben_n | input | 4*BYTES | Byte enables per beat, 0 means write |
| drain | input | 1 | Commit the oldest pending burst |
| cm_valid | output | 1 | Commit to the array in this cycle |
| cm_addr | output | ADDR_W | Address of the committed burst |
| cm_data | output | 4*BYTES*BYTE_W | Data of the committed burst |
| cm_ben_n | output | 4*BYTES | Byte enables of the committed burst |
| rd_addr | input | ADDR_W | Lookup address |
| rd_array_data | input | 4*BYTES*BYTE_W | Array contents at the lookup address |
| rd_data | output | 4*BYTES*BYTE_W | Coherent data for the lookup address |

## Verification
An eviction and a lookup can fall in the same cycle. When the third write arrives, the oldest burst goes out on the commit port, and a read to that same address is still in flight. Directed steps force this collision, placing the read on the evicted address at the moment of the write. Random steps also produce it often, because they draw addresses from a set of eight. The bench updates its array model only at the edge. It therefore expects the lookup to return the buffered bytes of the evicted burst, merged with the old array contents, and never the array after the commit.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

    localparam int BURST = 4;

    typedef enum logic [1:0] {
        PWB_IDLE  = 2'd0,
        PWB_WRITE = 2'd1,
        PWB_DRAIN = 2'd2
    } pwb_op_e;

    // write wins over drain in the same cycle
    function automatic pwb_op_e pwb_decode(input logic wr, input logic dr);
        if (wr)      return PWB_WRITE;
        else if (dr) return PWB_DRAIN;
        else         return PWB_IDLE;
    endfunction

endpackage

// File: rtl/pwb_store.sv
module pwb_store
    import pwb_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 128,
    parameter int MASK_W = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  pwb_op_e                     op,
    input  logic [ADDR_W-1:0]           in_addr,
    input  logic [DATA_W-1:0]           in_data,
    input  logic [MASK_W-1:0]           in_ben_n,
    output logic [1:0]                  slot_v,
    output logic [1:0][ADDR_W-1:0]      slot_a,
    output logic [1:0][DATA_W-1:0]      slot_d,
    output logic [1:0][MASK_W-1:0]      slot_b,
    output logic                        cm_valid,
    output logic [ADDR_W-1:0]           cm_addr,
    output logic [DATA_W-1:0]           cm_data,
    output logic [MASK_W-1:0]           cm_ben_n
);
    // slot 0 holds the newer burst, slot 1 the older one
    always_ff @(posedge clk) begin
        if (rst) begin
            slot_v <= '0;
        end else begin
            case (op)
                PWB_WRITE: begin
                    slot_v    <= {slot_v[0], 1'b1};
                    slot_a[1] <= slot_a[0];
                    slot_d[1] <= slot_d[0];
                    slot_b[1] <= slot_b[0];
                    slot_a[0] <= in_addr;
                    slot_d[0] <= in_data;
                    slot_b[0] <= in_ben_n;
                end
                PWB_DRAIN: begin
                    if (slot_v[1]) slot_v[1] <= 1'b0;
                    else           slot_v[0] <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    logic old_sel;
    assign old_sel = slot_v[1];

    always_comb begin
        cm_valid = 1'b0;
        if (op == PWB_WRITE)      cm_valid = slot_v[1];
        else if (op == PWB_DRAIN) cm_valid = |slot_v;
    end
    assign cm_addr  = slot_a[old_sel];
    assign cm_data  = slot_d[old_sel];
    assign cm_ben_n = slot_b[old_sel];

    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (rst)
        (op == PWB_WRITE) |=> (slot_v[0] && slot_a[0] == $past(in_addr)))
        else $error("write not loaded");                                  // R1
    AST_SHIFT_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        (op == PWB_WRITE && slot_v[0]) |=> (slot_v[1] && slot_a[1] == $past(slot_a[0])))
        else $error("newer burst not aged");                              // R2
    AST_NO_IDLE_COMMIT: assert property (@(posedge clk) disable iff (rst)
        (op == PWB_IDLE) |-> !cm_valid)
        else $error("commit without request");                            // R6
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (op == PWB_IDLE) |=> (slot_v == $past(slot_v)))
        else $error("pending set changed while idle");                    // R6
    AST_DRAIN_OLDEST: assert property (@(posedge clk) disable iff (rst)
        (op == PWB_DRAIN && slot_v[1]) |=> (!slot_v[1] && slot_v[0] == $past(slot_v[0])))
        else $error("drain did not remove oldest");                       // R7
endmodule

// File: rtl/pwb_merge.sv
module pwb_merge #(
    parameter int ADDR_W = 6,
    parameter int BYTE_W = 8,
    parameter int LANES  = 16,
    localparam int DATA_W = LANES * BYTE_W
) (
    input  logic [1:0]                  slot_v,
    input  logic [1:0][ADDR_W-1:0]      slot_a,
    input  logic [1:0][DATA_W-1:0]      slot_d,
    input  logic [1:0][LANES-1:0]       slot_b,
    input  logic [ADDR_W-1:0]           rd_addr,
    input  logic [DATA_W-1:0]           arr_data,
    output logic [1:0]                  hit,
    output logic [DATA_W-1:0]           rd_data
);
    for (genvar s = 0; s < 2; s++) begin : g_hit
        assign hit[s] = slot_v[s] && (slot_a[s] == rd_addr);
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic use_new, use_old;
        assign use_new = hit[0] && !slot_b[0][l];
        assign use_old = hit[1] && !slot_b[1][l];
        assign rd_data[l*BYTE_W +: BYTE_W] =
            use_new ? slot_d[0][l*BYTE_W +: BYTE_W] :
            use_old ? slot_d[1][l*BYTE_W +: BYTE_W] :
                      arr_data[l*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/posted_write_buffer.sv
module posted_write_buffer
    import pwb_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BYTE_W = 8,
    parameter int BYTES  = 4,
    localparam int LANES  = BURST * BYTES,
    localparam int DATA_W = LANES * BYTE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [LANES-1:0]   wr_ben_n,
    input  logic               drain,
    output logic               cm_valid,
    output logic [ADDR_W-1:0]  cm_addr,
    output logic [DATA_W-1:0]  cm_data,
    output logic [LANES-1:0]   cm_ben_n,
    input  logic [ADDR_W-1:0]  rd_addr,
    input  logic [DATA_W-1:0]  rd_array_data,
    output logic [DATA_W-1:0]  rd_data
);
    pwb_op_e                 op;
    logic [1:0]              slot_v;
    logic [1:0][ADDR_W-1:0]  slot_a;
    logic [1:0][DATA_W-1:0]  slot_d;
    logic [1:0][LANES-1:0]   slot_b;
    logic [1:0]              hit;

    assign op = pwb_decode(wr_en, drain);

    pwb_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MASK_W(LANES)) u_store (
        .clk(clk), .rst(rst), .op(op),
        .in_addr(wr_addr), .in_data(wr_data), .in_ben_n(wr_ben_n),
        .slot_v(slot_v), .slot_a(slot_a), .slot_d(slot_d), .slot_b(slot_b),
        .cm_valid(cm_valid), .cm_addr(cm_addr), .cm_data(cm_data), .cm_ben_n(cm_ben_n)
    );

    pwb_merge #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .LANES(LANES)) u_merge (
        .slot_v(slot_v), .slot_a(slot_a), .slot_d(slot_d), .slot_b(slot_b),
        .rd_addr(rd_addr), .arr_data(rd_array_data),
        .hit(hit), .rd_data(rd_data)
    );

    AST_FULL_HIT_FWD: assert property (@(posedge clk) disable iff (rst)
        (hit[0] && slot_b[0] == '0) |-> (rd_data == slot_d[0]))
        else $error("full newer hit not forwarded");                      // R3
    AST_MISS_PASS: assert property (@(posedge clk) disable iff (rst)
        (hit == 2'b00) |-> (rd_data == rd_array_data))
        else $error("miss altered array data");                           // R4
    AST_COMMIT_ON_THIRD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && cm_valid) |=> (slot_v == 2'b11))
        else $error("buffer not full after evicting write");              // R2
endmodule

// File: tb/tb_posted_write_buffer.sv
`timescale 1ns/1ps
module tb_posted_write_buffer;
    localparam int AW = 6;
    localparam int DW = 128;
    localparam int MW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0, drain = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [MW-1:0] wr_ben_n = '1;
    logic          cm_valid;
    logic [AW-1:0] cm_addr;
    logic [DW-1:0] cm_data, rd_data, rd_arr;
    logic [MW-1:0] cm_ben_n;

    logic [DW-1:0] mem [0:(1<<AW)-1];
    logic [1:0]          qv;
    logic [AW-1:0]       qa [0:1];
    logic [DW-1:0]       qd [0:1];
    logic [MW-1:0]       qb [0:1];
    int nchk = 0, nerr = 0;
    bit done = 0;

    assign rd_arr = mem[rd_addr];

    always #2 clk = ~clk;

    posted_write_buffer dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_ben_n(wr_ben_n), .drain(drain), .cm_valid(cm_valid), .cm_addr(cm_addr),
        .cm_data(cm_data), .cm_ben_n(cm_ben_n), .rd_addr(rd_addr),
        .rd_array_data(rd_arr), .rd_data(rd_data)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] rnd_data();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] ra);
        logic [DW-1:0] r;
        r = mem[ra];
        for (int l = 0; l < MW; l++) begin
            if (qv[0] && qa[0] == ra && !qb[0][l])      r[l*8 +: 8] = qd[0][l*8 +: 8];
            else if (qv[1] && qa[1] == ra && !qb[1][l]) r[l*8 +: 8] = qd[1][l*8 +: 8];
        end
        return r;
    endfunction

    task automatic step(input logic we, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                        input logic [MW-1:0] wb, input logic dr, input logic [AW-1:0] ra,
                        input string tc, input string tr);
        logic ecv;
        int   os;
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd; wr_ben_n = wb; drain = dr; rd_addr = ra;
        #1;
        os  = qv[1] ? 1 : 0;
        ecv = we ? qv[1] : (dr ? (qv != 2'b00) : 1'b0);
        check(tc, {127'b0, cm_valid}, {127'b0, ecv});
        if (ecv) begin
            check(tc, {{(DW-AW){1'b0}}, cm_addr}, {{(DW-AW){1'b0}}, qa[os]});
            check(tc, cm_data, qd[os]);
            check(tc, {{(DW-MW){1'b0}}, cm_ben_n}, {{(DW-MW){1'b0}}, qb[os]});
        end
        check(tr, rd_data, exp_read(ra));
        @(posedge clk);
        if (ecv)
            for (int l = 0; l < MW; l++)
                if (!qb[os][l]) mem[qa[os]][l*8 +: 8] = qd[os][l*8 +: 8];
        if (we) begin
            qv = {qv[0], 1'b1};
            qa[1] = qa[0]; qd[1] = qd[0]; qb[1] = qb[0];
            qa[0] = wa;    qd[0] = wd;    qb[0] = wb;
        end else if (dr) begin
            if (qv[1]) qv[1] = 1'b0; else qv[0] = 1'b0;
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d1;
        void'($urandom(32'd1234));
        for (int i = 0; i < (1<<AW); i++) mem[i] = rnd_data();
        qv = 2'b00;
        for (int i = 0; i < 2; i++) begin qa[i] = '0; qd[i] = '0; qb[i] = '1; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: empty after reset, reads pass array through
        step(0, 0, '0, '1, 0, 6'd3, "R1_reset_commit", "R1_reset_read");
        // R1/R3: first write then read-after-write, full enables
        d1 = rnd_data();
        step(1, 6'd5, d1, '0, 0, 6'd5, "R1_first_write", "R8_read_before_edge");
        step(0, 0, '0, '1, 0, 6'd5, "R6_idle", "R3_raw_full");
        check("R3_raw_beats", rd_data, d1);
        // R4: partial enables merge with array
        step(1, 6'd9, rnd_data(), 16'hA5C3, 0, 6'd1, "R1_second_write", "R4_miss");
        step(0, 0, '0, '1, 0, 6'd9, "R6_idle", "R4_partial_merge");
        // R2/R8: third write evicts addr 5 while reading addr 5
        step(1, 6'd9, rnd_data(), 16'h0FF0, 0, 6'd5, "R2_third_commit", "R8_evict_read");
        step(0, 0, '0, '1, 0, 6'd5, "R6_idle", "R2_after_commit");
        // R5: both entries match addr 9
        step(0, 0, '0, '1, 0, 6'd9, "R6_idle", "R5_newer_wins");
        // R7: write and drain together, write only
        step(1, 6'd2, rnd_data(), 16'h3333, 1, 6'd9, "R7_write_priority", "R5_mixed");
        step(0, 0, '0, '1, 1, 6'd9, "R7_drain_oldest", "R4_drain_read");
        step(0, 0, '0, '1, 1, 6'd2, "R7_drain_second", "R4_drain_read");
        step(0, 0, '0, '1, 1, 6'd2, "R7_drain_empty", "R1_empty_read");

        // constrained random mix, addresses limited to 0..7
        for (int i = 0; i < 600; i++) begin
            int  r;
            logic we, dr;
            r  = $urandom_range(0, 99);
            we = (r < 65);
            dr = (r >= 55 && r < 75);
            step(we, 6'($urandom_range(0, 7)), rnd_data(), 16'($urandom),
                 dr, 6'($urandom_range(0, 7)), "R2_rand_commit", "R4_rand_read");
        end

        step(0, 0, '0, '1, 1, 0, "R7_final_drain", "R4_final_read");
        step(0, 0, '0, '1, 1, 0, "R7_final_drain", "R4_final_read");
        for (int a = 0; a < 8; a++)
            step(0, 0, '0, '1, 0, 6'(a), "R6_final_idle", "R1_final_read");

        done = 1;
        summary();
        $finish;
    end
endmodule